// File: doc/BRIEF.md
# Circular Stream-to-Buffer Receive Engine

This block moves bytes arriving on a receiver's valid/data interface into an internal buffer whose active length software programs beforehand. Every accepted byte lands at the current write position, and the position then advances by one. Software reads the live write position, or the count still to go before the end, and works out how many fresh bytes lie between its own last read position and the write position. It then fetches them through a combinational read port into the buffer.

Two events mark progress: one when the write position reaches half of the programmed length, one when it reaches the full length. Each sets a sticky flag. Software clears a flag by writing a one to it, and each flag has its own interrupt enable. In circular mode the engine returns to the buffer start after the last element and keeps running without stopping, so the events recur on every pass. Bytes that software has not yet consumed are overwritten once the write position laps them. In one-shot mode the engine switches itself off after the full count.

Top module: `circ_rx_dma`

## Requirements
- R1: After reset the channel is disabled, the write pointer, the remaining count and the programmed length are zero, and both event flags and the interrupt are low.
- R2: A length write is taken only while the channel is disabled, and a value above the buffer depth is clamped to the depth. An enable request made while the stored length is zero leaves the channel disabled.
- R3: Each byte presented with rx_valid high while the channel is enabled is written at the write pointer, and the pointer then advances by one. A byte presented while the channel is disabled is dropped. rd_data shows the buffer entry at rd_addr in the same cycle.
- R4: The remaining count always equals the programmed length minus the write pointer, so it returns to the full length on every wrap.
- R5: The half flag sets on the byte that brings the pointer to the length divided by two, rounded down. With a length of 1 this event never occurs.
- R6: The complete flag sets on the byte that brings the pointer to the programmed length, and that byte returns the pointer to 0.
- R7: In circular mode (control bit 1 = 1) the channel stays enabled after the complete event, overwrites the buffer from address 0, and raises both events again on every pass.
- R8: In one-shot mode (control bit 1 = 0) the channel clears its enable after the complete event. Further bytes leave both the buffer and the pointer unchanged.
- R9: Both flags are sticky. Writing clr_mask with clr_we clears them (bit 0 = half, bit 1 = complete). A flag set in the same cycle as its clear stays set.
- R10: irq is high when the half flag is set with control bit 2 = 1, or when the complete flag is set with control bit 3 = 1.
- R11: A control write with bit 0 = 1 to a disabled channel enables it and resets the pointer to 0. A control write with bit 0 = 0 disables the channel and holds the pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_valid | input | 1 | Received byte present |
| rx_data | input | DATA_W | Received byte |
| ctl_we | input | 1 | Control write strobe |
| ctl_wdata | input | 4 | bit0 enable, bit1 circular, bit2 half irq enable, bit3 complete irq enable |
| len_we | input | 1 | Length write strobe |
| len_wdata | input | ADDR_W+1 | Number of elements per pass |
| clr_we | input | 1 | Flag clear strobe |
| clr_mask | input | 2 | Write-one-to-clear mask, bit0 half, bit1 complete |
| rd_addr | input | ADDR_W | Buffer read address |
| rd_data | output | DATA_W | Buffer content at rd_addr |
| ch_en | output | 1 | Channel enabled |
| wr_ptr | output | ADDR_W | Current write position |
| remaining | output | ADDR_W+1 | Elements left before the end of the pass |
| ht_flag | output | 1 | Half event flag |
| tc_flag | output | 1 | Complete event flag |
| irq | output | 1 | Interrupt request |

## Verification
An event can set a flag in the same cycle that software writes a one to clear it. The bench provokes this by presenting the byte that reaches the half mark, and later the byte that reaches the end, together with a clear strobe that names that same flag. A correct design leaves the flag set after the collision, and a separate clear on its own in the next step drops it. The other flag must be untouched throughout.

// File: rtl/circ_dma_pkg.sv
package circ_dma_pkg;

  localparam int NUM_EV = 2;

  typedef struct packed {
    logic tc_ie;
    logic ht_ie;
    logic circ;
    logic en;
  } ctl_t;

  function automatic int unsigned half_mark(int unsigned len);
    return len >> 1;
  endfunction

  function automatic int unsigned clamp_len(int unsigned req, int unsigned depth);
    return (req > depth) ? depth : req;
  endfunction

  function automatic int unsigned left_count(int unsigned len, int unsigned ptr);
    return len - ptr;
  endfunction

endpackage

// File: rtl/circ_dma_ram.sv
module circ_dma_ram #(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/circ_dma_flag.sv
module circ_dma_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  input  logic ie,
  output logic flag,
  output logic irq_part
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   flag <= 1'b0;
    else if (set) flag <= 1'b1;
    else if (clr) flag <= 1'b0;
  end

  assign irq_part = flag & ie;
endmodule

// File: rtl/circ_dma_ptr.sv
module circ_dma_ptr
  import circ_dma_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic              ctl_we,
  input  ctl_t              ctl_wdata,
  input  logic              len_we,
  input  logic [ADDR_W:0]   len_wdata,
  output ctl_t              ctl_q,
  output logic [ADDR_W:0]   len_q,
  output logic [ADDR_W-1:0] wr_ptr,
  output logic [ADDR_W:0]   remaining,
  output logic              fire,
  output logic              ev_ht,
  output logic              ev_tc
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int CNT_W = ADDR_W + 1;

  logic [CNT_W-1:0] ptr_nx;
  logic [CNT_W-1:0] half_w;

  assign fire   = rx_valid & ctl_q.en;
  assign ptr_nx = {1'b0, wr_ptr} + CNT_W'(1);
  assign half_w = CNT_W'(half_mark(32'(len_q)));
  assign ev_tc  = fire && (ptr_nx == len_q);
  assign ev_ht  = fire && (half_w != '0) && (ptr_nx == half_w);

  assign remaining = CNT_W'(left_count(32'(len_q), 32'(wr_ptr)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q  <= '0;
      len_q  <= '0;
      wr_ptr <= '0;
    end else begin
      if (len_we && !ctl_q.en)
        len_q <= CNT_W'(clamp_len(32'(len_wdata), DEPTH));
      if (ctl_we) begin
        ctl_q.circ  <= ctl_wdata.circ;
        ctl_q.ht_ie <= ctl_wdata.ht_ie;
        ctl_q.tc_ie <= ctl_wdata.tc_ie;
        if (!ctl_wdata.en) begin
          ctl_q.en <= 1'b0;
        end else if (!ctl_q.en && (len_q != '0)) begin
          ctl_q.en <= 1'b1;
          wr_ptr   <= '0;
        end
      end
      if (fire) begin
        wr_ptr <= ev_tc ? '0 : ptr_nx[ADDR_W-1:0];
        if (ev_tc && !ctl_q.circ) ctl_q.en <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/circ_rx_dma.sv
module circ_rx_dma
  import circ_dma_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic [DATA_W-1:0] rx_data,
  input  logic              ctl_we,
  input  logic [3:0]        ctl_wdata,
  input  logic              len_we,
  input  logic [ADDR_W:0]   len_wdata,
  input  logic              clr_we,
  input  logic [1:0]        clr_mask,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              ch_en,
  output logic [ADDR_W-1:0] wr_ptr,
  output logic [ADDR_W:0]   remaining,
  output logic              ht_flag,
  output logic              tc_flag,
  output logic              irq
);
  ctl_t              ctl_q;
  logic [ADDR_W:0]   len_q;
  logic              fire;
  logic              ev_ht;
  logic              ev_tc;
  logic              mode_circ;
  logic [NUM_EV-1:0] ev_vec;
  logic [NUM_EV-1:0] ie_vec;
  logic [NUM_EV-1:0] flag_vec;
  logic [NUM_EV-1:0] irq_vec;

  circ_dma_ptr #(.ADDR_W(ADDR_W)) u_ptr (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_valid  (rx_valid),
    .ctl_we    (ctl_we),
    .ctl_wdata (ctl_t'(ctl_wdata)),
    .len_we    (len_we),
    .len_wdata (len_wdata),
    .ctl_q     (ctl_q),
    .len_q     (len_q),
    .wr_ptr    (wr_ptr),
    .remaining (remaining),
    .fire      (fire),
    .ev_ht     (ev_ht),
    .ev_tc     (ev_tc)
  );

  circ_dma_ram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ram (
    .clk   (clk),
    .we    (fire),
    .waddr (wr_ptr),
    .wdata (rx_data),
    .raddr (rd_addr),
    .rdata (rd_data)
  );

  assign ev_vec = {ev_tc, ev_ht};
  assign ie_vec = {ctl_q.tc_ie, ctl_q.ht_ie};

  for (genvar g = 0; g < NUM_EV; g++) begin : g_flag
    circ_dma_flag u_flag (
      .clk      (clk),
      .rst_n    (rst_n),
      .set      (ev_vec[g]),
      .clr      (clr_we & clr_mask[g]),
      .ie       (ie_vec[g]),
      .flag     (flag_vec[g]),
      .irq_part (irq_vec[g])
    );
  end

  assign mode_circ = ctl_q.circ;
  assign ch_en     = ctl_q.en;
  assign ht_flag   = flag_vec[0];
  assign tc_flag   = flag_vec[1];
  assign irq       = |irq_vec;
endmodule

// File: rtl/circ_rx_dma_chk.sv
module circ_rx_dma_chk #(
  parameter int ADDR_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              fire,
  input logic              ch_en,
  input logic              circ,
  input logic [ADDR_W-1:0] wr_ptr,
  input logic [ADDR_W:0]   remaining,
  input logic [ADDR_W:0]   len_q,
  input logic              len_we,
  input logic              ev_ht,
  input logic              ev_tc,
  input logic              ht_flag,
  input logic              tc_flag,
  input logic              clr_we,
  input logic [1:0]        clr_mask,
  input logic              irq
);
  localparam int CNT_W = ADDR_W + 1;
  localparam int DEPTH = 1 << ADDR_W;

  // R2
  len_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_en && len_we) |=> $stable(len_q));

  // R2
  len_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    32'(len_q) <= DEPTH);

  // R3
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !ev_tc) |=> (wr_ptr == $past(wr_ptr) + ADDR_W'(1)));

  // R4
  left_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !ev_tc) |=> (remaining == $past(remaining) - CNT_W'(1)));

  // R5
  half_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ht |=> ht_flag);

  // R6
  wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_tc |=> (tc_flag && wr_ptr == '0 && remaining == len_q));

  // R8
  oneshot_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_tc && !circ) |=> !ch_en);

  // R9
  ht_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ht_flag && !(clr_we && clr_mask[0])) |=> ht_flag);

  // R9
  tc_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tc_flag && !(clr_we && clr_mask[1])) |=> tc_flag);

  // R10
  irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (ht_flag || tc_flag));
endmodule

bind circ_rx_dma circ_rx_dma_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .fire      (fire),
  .ch_en     (ch_en),
  .circ      (mode_circ),
  .wr_ptr    (wr_ptr),
  .remaining (remaining),
  .len_q     (len_q),
  .len_we    (len_we),
  .ev_ht     (ev_ht),
  .ev_tc     (ev_tc),
  .ht_flag   (ht_flag),
  .tc_flag   (tc_flag),
  .clr_we    (clr_we),
  .clr_mask  (clr_mask),
  .irq       (irq)
);

// File: tb/circ_rx_dma_bench.sv
module circ_rx_dma_bench;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 5;
  localparam int DATA_W = 8;
  localparam int NVEC = 10;

  typedef struct packed {
    logic [7:0] len;
    logic       circ;
    logic [7:0] n;
    logic [7:0] ptr;
    logic       ht;
    logic       tc;
    logic       en;
    logic [7:0] rem;
  } vec_t;

  // len, circular, bytes pushed, expected pointer, half, complete, enable, remaining
  localparam vec_t VEC [NVEC] = '{
    '{8'd10, 1'b1, 8'd4,  8'd4,  1'b0, 1'b0, 1'b1, 8'd6},
    '{8'd10, 1'b1, 8'd5,  8'd5,  1'b1, 1'b0, 1'b1, 8'd5},
    '{8'd10, 1'b1, 8'd10, 8'd0,  1'b1, 1'b1, 1'b1, 8'd10},
    '{8'd10, 1'b1, 8'd13, 8'd3,  1'b1, 1'b1, 1'b1, 8'd7},
    '{8'd10, 1'b0, 8'd10, 8'd0,  1'b1, 1'b1, 1'b0, 8'd10},
    '{8'd10, 1'b0, 8'd14, 8'd0,  1'b1, 1'b1, 1'b0, 8'd10},
    '{8'd7,  1'b1, 8'd3,  8'd3,  1'b1, 1'b0, 1'b1, 8'd4},
    '{8'd32, 1'b1, 8'd16, 8'd16, 1'b1, 1'b0, 1'b1, 8'd16},
    '{8'd32, 1'b1, 8'd31, 8'd31, 1'b1, 1'b0, 1'b1, 8'd1},
    '{8'd1,  1'b1, 8'd3,  8'd0,  1'b0, 1'b1, 1'b1, 8'd1}
  };

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              rx_valid = 1'b0;
  logic [DATA_W-1:0] rx_data = '0;
  logic              ctl_we = 1'b0;
  logic [3:0]        ctl_wdata = '0;
  logic              len_we = 1'b0;
  logic [ADDR_W:0]   len_wdata = '0;
  logic              clr_we = 1'b0;
  logic [1:0]        clr_mask = '0;
  logic [ADDR_W-1:0] rd_addr = '0;
  logic [DATA_W-1:0] rd_data;
  logic              ch_en;
  logic [ADDR_W-1:0] wr_ptr;
  logic [ADDR_W:0]   remaining;
  logic              ht_flag;
  logic              tc_flag;
  logic              irq;

  int total = 0;
  int fails = 0;
  bit done = 1'b0;

  circ_rx_dma #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_circ_rx_dma (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
    .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .len_we(len_we), .len_wdata(len_wdata),
    .clr_we(clr_we), .clr_mask(clr_mask), .rd_addr(rd_addr), .rd_data(rd_data),
    .ch_en(ch_en), .wr_ptr(wr_ptr), .remaining(remaining),
    .ht_flag(ht_flag), .tc_flag(tc_flag), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(string req, string what, int act, int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic set_ctl(bit en, bit circ, bit hie, bit tie);
    ctl_we = 1'b1; ctl_wdata = {tie, hie, circ, en};
    @(negedge clk);
    ctl_we = 1'b0;
  endtask

  task automatic set_len(int v);
    len_we = 1'b1; len_wdata = (ADDR_W+1)'(v);
    @(negedge clk);
    len_we = 1'b0;
  endtask

  task automatic clear(logic [1:0] m);
    clr_we = 1'b1; clr_mask = m;
    @(negedge clk);
    clr_we = 1'b0; clr_mask = '0;
  endtask

  task automatic push(int n, int base);
    for (int i = 0; i < n; i++) begin
      rx_valid = 1'b1; rx_data = DATA_W'(base + i);
      @(negedge clk);
    end
    rx_valid = 1'b0;
  endtask

  task automatic push_clr(logic [1:0] m, int d);
    rx_valid = 1'b1; rx_data = DATA_W'(d); clr_we = 1'b1; clr_mask = m;
    @(negedge clk);
    rx_valid = 1'b0; clr_we = 1'b0; clr_mask = '0;
  endtask

  task automatic peek(string req, int a, int exp);
    rd_addr = ADDR_W'(a);
    #1;
    chk(req, "buffer byte", int'(rd_data), exp);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "enable", int'(ch_en), 0);
    chk("R1", "pointer", int'(wr_ptr), 0);
    chk("R1", "remaining", int'(remaining), 0);
    chk("R1", "half flag", int'(ht_flag), 0);
    chk("R1", "complete flag", int'(tc_flag), 0);
    chk("R1", "irq", int'(irq), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // table walk: R4 R5 R6 R7 R8
    for (int v = 0; v < NVEC; v++) begin
      set_ctl(1'b0, 1'b0, 1'b0, 1'b0);
      clear(2'b11);
      set_len(int'(VEC[v].len));
      set_ctl(1'b1, VEC[v].circ, 1'b0, 1'b0);
      push(int'(VEC[v].n), 0);
      chk("R6", $sformatf("vec %0d pointer", v), int'(wr_ptr), int'(VEC[v].ptr));
      chk("R5", $sformatf("vec %0d half", v), int'(ht_flag), int'(VEC[v].ht));
      chk("R6", $sformatf("vec %0d complete", v), int'(tc_flag), int'(VEC[v].tc));
      chk("R8", $sformatf("vec %0d enable", v), int'(ch_en), int'(VEC[v].en));
      chk("R4", $sformatf("vec %0d remaining", v), int'(remaining), int'(VEC[v].rem));
    end

    // R3 R7 storage and overwrite on lap
    set_ctl(1'b0, 1'b0, 1'b0, 1'b0);
    set_len(10);
    set_ctl(1'b1, 1'b1, 1'b0, 1'b0);
    push(13, 8'h40);
    peek("R7", 0, 8'h4A);
    peek("R7", 2, 8'h4C);
    peek("R3", 3, 8'h43);
    peek("R3", 9, 8'h49);

    // R11 disable holds pointer, bytes dropped
    set_ctl(1'b0, 1'b1, 1'b0, 1'b0);
    chk("R11", "enable after stop", int'(ch_en), 0);
    push(1, 8'hEE);
    chk("R11", "pointer held", int'(wr_ptr), 3);
    peek("R3", 3, 8'h43);
    set_ctl(1'b1, 1'b1, 1'b0, 1'b0);
    chk("R11", "pointer after re-enable", int'(wr_ptr), 0);

    // R2 length write ignored while enabled
    set_len(20);
    chk("R2", "remaining after live length write", int'(remaining), 10);
    set_ctl(1'b0, 1'b0, 1'b0, 1'b0);
    set_len(0);
    set_ctl(1'b1, 1'b1, 1'b0, 1'b0);
    chk("R2", "enable with zero length", int'(ch_en), 0);
    set_len(50);
    chk("R2", "clamped length", int'(remaining), 32);

    // R8 one-shot ignores trailing bytes
    clear(2'b11);
    set_len(4);
    set_ctl(1'b1, 1'b0, 1'b0, 1'b0);
    push(4, 8'h10);
    chk("R8", "enable after one-shot", int'(ch_en), 0);
    push(1, 8'hEE);
    peek("R8", 0, 8'h10);
    chk("R8", "pointer after extra byte", int'(wr_ptr), 0);

    // R9 set wins over same-cycle clear
    clear(2'b11);
    set_ctl(1'b1, 1'b1, 1'b0, 1'b0);
    push(1, 1);
    push_clr(2'b01, 2);
    chk("R9", "half after collision", int'(ht_flag), 1);
    chk("R9", "complete untouched", int'(tc_flag), 0);
    clear(2'b01);
    chk("R9", "half after clear", int'(ht_flag), 0);
    push(1, 3);
    push_clr(2'b10, 4);
    chk("R9", "complete after collision", int'(tc_flag), 1);
    clear(2'b11);
    chk("R9", "complete after clear", int'(tc_flag), 0);

    // R10 interrupt masking
    push(2, 5);
    chk("R10", "irq with enables off", int'(irq), 0);
    set_ctl(1'b1, 1'b1, 1'b1, 1'b0);
    chk("R10", "irq half enabled", int'(irq), 1);
    set_ctl(1'b1, 1'b1, 1'b0, 1'b1);
    chk("R10", "irq complete only, no flag", int'(irq), 0);
    push(2, 7);
    chk("R10", "irq complete enabled", int'(irq), 1);

    // R5 no half event with length 1
    set_ctl(1'b0, 1'b0, 1'b0, 1'b0);
    clear(2'b11);
    set_len(1);
    set_ctl(1'b1, 1'b1, 1'b0, 1'b0);
    push(1, 9);
    chk("R5", "half with length 1", int'(ht_flag), 0);
    chk("R6", "complete with length 1", int'(tc_flag), 1);

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule